// File: doc/BRIEF.md
# Dual-Output Line Delay Memory

This block buffers one stream of raster pixels and returns, for each horizontal position, the pixel from the previous scan line and the pixel from the line before that. Both come out together. Filters that work across several lines can therefore see three vertically aligned samples: the live input plus the two delayed outputs. Storage is two cascaded line stores of `LINE_LEN` words of `DATA_W` bits each. When a word is written into the first store, the word it replaces moves down into the second store.

The write side and the read side each have their own clock, enable and counter reset, and they run with no fixed relation to each other. This lets the block sit between a producer and a consumer that process data at different rates. Each side steps its own address counter. The counter returns to zero on a reset and wraps after the last word of a line. The storage arrays are not cleared by either reset. The delayed outputs are registered on the read clock, and a valid flag marks the cycles in which they were refreshed.

Top module: `dual_line_delay`

## Requirements
- R1: With `wrst` high at a `wclk` rising edge, the write position becomes 0, so the next enabled write lands at address 0.
- R2: With `rrst` high at a `rclk` rising edge, the read position becomes 0, and after that edge `q_valid` is 0 and both `q_line1` and `q_line2` are 0.
- R3: A `wclk` edge with `wen` low stores nothing and leaves the write position where it was, whatever value `din` has.
- R4: A `rclk` edge with `ren` low (and `rrst` low) leaves the read position unchanged, keeps both outputs at their previous values and drives `q_valid` to 0.
- R5: An enabled write at address A copies the word held in the first store at A into the second store at A, and puts `din` into the first store at A.
- R6: An enabled read at address A registers the first store's word at A onto `q_line1` and the second store's word at A onto `q_line2`, with `q_valid` at 1 after that `rclk` edge, and then advances the read position by one.
- R7: Both positions count up from 0 to `LINE_LEN`-1 and then wrap to 0 on the next enabled access, with no reset needed.
- R8: When a reset and the enable of the same side are high at the same edge, only the reset acts: no byte is stored on the write side, and on the read side the outputs clear and are not loaded.
- R9: Read data are correct when `rclk` runs at a different period and phase from `wclk`, as long as a word is written before it is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Write position reset, synchronous to `wclk`, active high |
| wen | input | 1 | Write enable, active high |
| din | input | DATA_W | Incoming pixel |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Read position reset, synchronous to `rclk`, active high |
| ren | input | 1 | Read enable, active high |
| q_line1 | output | DATA_W | Pixel from one line earlier |
| q_line2 | output | DATA_W | Pixel from two lines earlier |
| q_valid | output | 1 | High after an edge on which the outputs were loaded |

## Verification
The case most likely to hide a fault is a counter reset that arrives on the same edge as that side's enable, because a wrong priority either stores a byte or loads the outputs. The bench raises `wrst` and `wen` together with a marker byte on `din`. It then makes an ordinary write at address 0 and reads that address back: the one-line output must show the new byte and the two-line output must show the word that was there before. If the marker shows up in either output, the write happened when it should not have. On the read side, `rrst` and `ren` are raised together after a valid read. The outputs must come back as zero with `q_valid` low, and the next read must return address 0.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

   // Number of cascaded line stores; the top maps tap 0 and tap 1 to its outputs.
   localparam int NUM_TAPS = 2;

   // Address width needed to count through a line of the given depth.
   function automatic int ldm_addr_w(input int depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/ldm_addr_ctr.sv
module ldm_addr_ctr #(
   parameter int DEPTH = 1280,
   parameter int AW    = 11
) (
   input  logic          clk,
   input  logic          clr,
   input  logic          adv,
   output logic [AW-1:0] addr
);

   localparam bit POW2 = (DEPTH == (1 << AW));

   if (DEPTH < 2) begin : g_bad_depth
      $error("ldm_addr_ctr: DEPTH must be at least 2");
   end
   if (DEPTH > (1 << AW)) begin : g_bad_aw
      $error("ldm_addr_ctr: AW too narrow for DEPTH");
   end

   logic [AW-1:0] nxt;

   generate
      if (POW2) begin : g_pow2
         // Natural roll-over of the counter is the wrap.
         assign nxt = addr + AW'(1);
      end else begin : g_cmp
         localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
         assign nxt = (addr == LAST) ? '0 : addr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr) begin
         addr <= '0;
      end else if (adv) begin
         addr <= nxt;
      end
   end

endmodule

// File: rtl/ldm_line_store.sv
module ldm_line_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 1280,
   parameter int AW     = 11,
   parameter int TAPS   = 2
) (
   input  logic                         wclk,
   input  logic                         wr_en,
   input  logic [AW-1:0]                wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [AW-1:0]                rd_addr,
   output logic [TAPS-1:0][DATA_W-1:0]  rd_taps
);

   if (TAPS < 2) begin : g_bad_taps
      $error("ldm_line_store: TAPS must be at least 2");
   end

   // new_word[k]: value written into store k; old_word[k]: word leaving store k.
   logic [TAPS-1:0][DATA_W-1:0] new_word;
   logic [TAPS-2:0][DATA_W-1:0] old_word;

   generate
      for (genvar k = 0; k < TAPS; k++) begin : g_tap
         logic [DATA_W-1:0] mem [DEPTH];

         if (k == 0) begin : g_head
            assign new_word[k] = wr_data;
         end else begin : g_chain
            assign new_word[k] = old_word[k-1];
         end

         if (k < TAPS - 1) begin : g_spill
            assign old_word[k] = mem[wr_addr];
         end

         assign rd_taps[k] = mem[rd_addr];

         always_ff @(posedge wclk) begin
            if (wr_en) begin
               mem[wr_addr] <= new_word[k];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ldm_read_port.sv
module ldm_read_port #(
   parameter int DATA_W = 8,
   parameter int TAPS   = 2
) (
   input  logic                         rclk,
   input  logic                         rst,
   input  logic                         en,
   input  logic [TAPS-1:0][DATA_W-1:0]  taps_in,
   output logic [TAPS-1:0][DATA_W-1:0]  q,
   output logic                         valid
);

   always_ff @(posedge rclk) begin
      if (rst) begin
         q     <= '0;
         valid <= 1'b0;
      end else if (en) begin
         q     <= taps_in;
         valid <= 1'b1;
      end else begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/dual_line_delay.sv
module dual_line_delay
   import ldm_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int LINE_LEN = 1280
) (
   input  logic              wclk,
   input  logic              wrst,
   input  logic              wen,
   input  logic [DATA_W-1:0] din,
   input  logic              rclk,
   input  logic              rrst,
   input  logic              ren,
   output logic [DATA_W-1:0] q_line1,
   output logic [DATA_W-1:0] q_line2,
   output logic              q_valid
);

   localparam int AW = ldm_addr_w(LINE_LEN);

   if (DATA_W < 1) begin : g_bad_width
      $error("dual_line_delay: DATA_W must be positive");
   end
   if (LINE_LEN < 2) begin : g_bad_len
      $error("dual_line_delay: LINE_LEN must be at least 2");
   end
   if (NUM_TAPS != 2) begin : g_bad_taps
      $error("dual_line_delay: two taps are mapped to the outputs");
   end

   logic [AW-1:0]                   w_addr;
   logic [AW-1:0]                   r_addr;
   logic                            w_go;
   logic                            r_go;
   logic [NUM_TAPS-1:0][DATA_W-1:0] taps;
   logic [NUM_TAPS-1:0][DATA_W-1:0] q_all;

   // Reset outranks enable on each side.
   assign w_go = wen & ~wrst;
   assign r_go = ren & ~rrst;

   ldm_addr_ctr #(.DEPTH(LINE_LEN), .AW(AW)) u_wctr (
      .clk  (wclk),
      .clr  (wrst),
      .adv  (w_go),
      .addr (w_addr)
   );

   ldm_addr_ctr #(.DEPTH(LINE_LEN), .AW(AW)) u_rctr (
      .clk  (rclk),
      .clr  (rrst),
      .adv  (r_go),
      .addr (r_addr)
   );

   ldm_line_store #(
      .DATA_W (DATA_W),
      .DEPTH  (LINE_LEN),
      .AW     (AW),
      .TAPS   (NUM_TAPS)
   ) u_store (
      .wclk    (wclk),
      .wr_en   (w_go),
      .wr_addr (w_addr),
      .wr_data (din),
      .rd_addr (r_addr),
      .rd_taps (taps)
   );

   ldm_read_port #(.DATA_W(DATA_W), .TAPS(NUM_TAPS)) u_rport (
      .rclk    (rclk),
      .rst     (rrst),
      .en      (r_go),
      .taps_in (taps),
      .q       (q_all),
      .valid   (q_valid)
   );

   assign q_line1 = q_all[0];
   assign q_line2 = q_all[1];

endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
   parameter int DATA_W   = 8,
   parameter int LINE_LEN = 1280,
   parameter int AW       = 11
) (
   input logic              wclk,
   input logic              wrst,
   input logic              wen,
   input logic              rclk,
   input logic              rrst,
   input logic              ren,
   input logic [DATA_W-1:0] q_line1,
   input logic [DATA_W-1:0] q_line2,
   input logic              q_valid,
   input logic [AW-1:0]     w_addr,
   input logic [AW-1:0]     r_addr
);

   localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

   // Each side is checked only once its counter has seen a reset.
   logic w_seen = 1'b0;
   logic r_seen = 1'b0;

   always_ff @(posedge wclk) if (wrst) w_seen <= 1'b1;
   always_ff @(posedge rclk) if (rrst) r_seen <= 1'b1;

   p_wreset_r1: assert property (@(posedge wclk) disable iff (!w_seen)
      wrst |=> (w_addr == '0));

   p_rreset_r2: assert property (@(posedge rclk) disable iff (!r_seen)
      rrst |=> (r_addr == '0) && !q_valid && (q_line1 == '0) && (q_line2 == '0));

   p_wen_idle_r3: assert property (@(posedge wclk) disable iff (!w_seen)
      (!wrst && !wen) |=> $stable(w_addr));

   p_hold_r4: assert property (@(posedge rclk) disable iff (!r_seen)
      (!rrst && !ren) |=> !q_valid && $stable(q_line1) && $stable(q_line2) && $stable(r_addr));

   p_rd_valid_r6: assert property (@(posedge rclk) disable iff (!r_seen)
      (!rrst && ren) |=> q_valid);

   p_wwrap_r7: assert property (@(posedge wclk) disable iff (!w_seen)
      (!wrst && wen && (w_addr == LAST)) |=> (w_addr == '0));

   p_rwrap_r7: assert property (@(posedge rclk) disable iff (!r_seen)
      (!rrst && ren && (r_addr == LAST)) |=> (r_addr == '0));

   p_rcollide_r8: assert property (@(posedge rclk) disable iff (!r_seen)
      (rrst && ren) |=> !q_valid && (q_line1 == '0));

endmodule

bind dual_line_delay ldm_checker #(
   .DATA_W   (DATA_W),
   .LINE_LEN (LINE_LEN),
   .AW       (AW)
) u_chk (
   .wclk    (wclk),
   .wrst    (wrst),
   .wen     (wen),
   .rclk    (rclk),
   .rrst    (rrst),
   .ren     (ren),
   .q_line1 (q_line1),
   .q_line2 (q_line2),
   .q_valid (q_valid),
   .w_addr  (w_addr),
   .r_addr  (r_addr)
);

// File: tb/sim_dual_line_delay.sv
module sim_dual_line_delay;

   localparam int CLK_PERIOD  = 10;
   localparam int RCLK_PERIOD = 14;
   localparam int L           = 12;
   localparam int DW          = 8;

   logic          wclk = 1'b0;
   logic          rclk = 1'b0;
   logic          wrst = 1'b0;
   logic          wen  = 1'b0;
   logic [DW-1:0] din  = '0;
   logic          rrst = 1'b0;
   logic          ren  = 1'b0;
   logic [DW-1:0] q_line1;
   logic [DW-1:0] q_line2;
   logic          q_valid;

   always #(CLK_PERIOD/2)  wclk = ~wclk;
   always #(RCLK_PERIOD/2) rclk = ~rclk;

   dual_line_delay #(.DATA_W(DW), .LINE_LEN(L)) u0 (
      .wclk(wclk), .wrst(wrst), .wen(wen), .din(din),
      .rclk(rclk), .rrst(rrst), .ren(ren),
      .q_line1(q_line1), .q_line2(q_line2), .q_valid(q_valid)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Bench model of the two stores and both positions.
   logic [DW-1:0] m1 [L];
   logic [DW-1:0] m2 [L];
   int wpos = 0;
   int rpos = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [DW-1:0] d);
      @(negedge wclk); wen = 1'b1; din = d;
      @(negedge wclk); wen = 1'b0;
      m2[wpos] = m1[wpos];
      m1[wpos] = d;
      wpos = (wpos + 1) % L;
   endtask

   task automatic wreset();
      @(negedge wclk); wrst = 1'b1;
      @(negedge wclk); wrst = 1'b0;
      wpos = 0;
   endtask

   task automatic rreset(input string req);
      @(negedge rclk); rrst = 1'b1;
      @(negedge rclk); rrst = 1'b0;
      rpos = 0;
      check(req, "valid after read reset", int'(q_valid), 0);
      check(req, "line1 after read reset", int'(q_line1), 0);
      check(req, "line2 after read reset", int'(q_line2), 0);
   endtask

   task automatic rd_check(input string req);
      @(negedge rclk); ren = 1'b1;
      @(negedge rclk); ren = 1'b0;
      check(req, "valid on read", int'(q_valid), 1);
      check(req, $sformatf("line1 at %0d", rpos), int'(q_line1), int'(m1[rpos]));
      check(req, $sformatf("line2 at %0d", rpos), int'(q_line2), int'(m2[rpos]));
      rpos = (rpos + 1) % L;
   endtask

   // R5 R6 R9: two full lines, then a full read on the slower read clock; R7 read wrap.
   task automatic t_fill();
      for (int ln = 0; ln < 2; ln++) begin
         for (int i = 0; i < L; i++) begin
            wr(DW'((ln * L + i) * 7 + 3));
         end
      end
      rreset("R2");
      for (int i = 0; i < L; i++) rd_check("R6 R5 R9");
      rd_check("R7 read wrap");
   endtask

   // R4: outputs hold and valid drops while reads are off.
   task automatic t_hold();
      logic [DW-1:0] a, b;
      a = q_line1; b = q_line2;
      repeat (3) @(negedge rclk);
      check("R4", "valid idle", int'(q_valid), 0);
      check("R4", "line1 held", int'(q_line1), int'(a));
      check("R4", "line2 held", int'(q_line2), int'(b));
      rd_check("R4 position kept");
   endtask

   // R3 R7: idle write edges change nothing; next write lands at the wrapped position 0.
   task automatic t_wen_idle();
      for (int i = 0; i < 5; i++) begin
         @(negedge wclk); din = DW'(8'hF0 + i);
      end
      wr(8'hA5);
      rreset("R2");
      for (int i = 0; i < L; i++) rd_check("R3 R7");
   endtask

   // R1: write reset returns the write position to 0.
   task automatic t_wrst();
      wr(8'h11); wr(8'h22); wr(8'h33);
      wreset();
      wr(8'h3C);
      rreset("R2");
      for (int i = 0; i < 5; i++) rd_check("R1");
   endtask

   // R8: reset and enable on the same edge, both sides.
   task automatic t_collide();
      @(negedge wclk); wrst = 1'b1; wen = 1'b1; din = 8'hEE;
      @(negedge wclk); wrst = 1'b0; wen = 1'b0;
      wpos = 0;
      wr(8'h77);
      rreset("R2");
      rd_check("R8 write side");
      @(negedge rclk); rrst = 1'b1; ren = 1'b1;
      @(negedge rclk); rrst = 1'b0; ren = 1'b0;
      rpos = 0;
      check("R8", "valid after reset+enable", int'(q_valid), 0);
      check("R8", "line1 after reset+enable", int'(q_line1), 0);
      check("R8", "line2 after reset+enable", int'(q_line2), 0);
      rd_check("R8 read side");
   endtask

   initial begin
      wreset();
      rreset("R2 reset state");
      t_fill();
      t_hold();
      t_wen_idle();
      t_wrst();
      t_collide();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule